// File: doc/BRIEF.md
# Bit-Banged MDIO Management Slave

This block stands in for the management side of an Ethernet PHY. Software has no real serial wire to drive. It writes a small control word whose bits carry a management clock, an outgoing data bit and an output enable. It reads back an incoming data bit from the same word. The block follows those writes as if they were a serial management frame.

The block samples one bit on every low-to-high step of the clock bit. A run of thirty-two ones arms it for a new frame. It then decodes the sixteen header bits that follow. A read frame drives the addressed register onto the incoming data bit, most significant bit first. A write frame stores the sixteen data bits that follow the header. The register file has 32 words of 16 bits. Two identifier words are restored on every reset. The PHY address field is carried in the frame but plays no part in selecting a register, so every address reaches the same PHY.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A bit is sampled only when a host write sets the clock bit (control bit 2) to 1 while the clock level stored from the previous host write was 0. Every host write updates the stored clock level, and a write that keeps the clock at 1 samples nothing.
- R2: The sampled bit is 1 only when the data-out bit (control bit 0) and the output-enable bit (control bit 1) are both 1. It is shifted into a 32-bit register from the least significant side.
- R3: When the 32-bit shift register holds all ones after a sample, the frame counter is loaded with 32. Otherwise each sample lowers a non-zero counter by one. Without that preamble no frame is decoded, and a preamble sent in the middle of a frame starts a new one.
- R4: When the counter reaches 16, the last 16 bits sent, in order, are decoded as start (2 bits, must be 01), opcode (2 bits, 01 = write, 10 = read), PHY address (5 bits), register address (5 bits) and turnaround (2 bits). A bad start or opcode leaves the block idle.
- R5: A write header is accepted only when its turnaround bits are 1 then 0. Any other turnaround value drops the frame, and no register changes.
- R6: A read header is accepted only when the second turnaround bit is 0. A read with that bit at 1 is dropped, and the data-in bit keeps its value.
- R7: On an accepted read, the addressed register is captured at decode time. On each of the next 16 samples the data-in bit (control bit 3) shows the next bit, most significant first.
- R8: On an accepted write, the 16 bits sampled after the header are stored when the counter reaches 0, whatever their values. The PHY address is ignored, and the 5-bit register address selects one of 32 words.
- R9: The data-in bit is read-only. A host write never changes it. The read-back word shows the last value written on bits 2..0 and the data-in bit on bit 3.
- R10: Reset clears the control word, the shift register, the counter, the decode state and every register. Then word 2 is set to 0x0022 and word 3 to 0x161A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the control word |
| host_wdata | input | 4 | Control word written: bit0 data-out, bit1 output-enable, bit2 clock, bit3 ignored |
| host_rdata | output | 4 | Control word read back: bits 2..0 as last written, bit3 data-in |

## Verification
A table of write and read frames covers several register addresses and PHY addresses. Its data values have their ones placed differently, so a register selected from the wrong field, or bits shifted the wrong way, shows up as a mismatch. Directed frames then test the rules that set an accepted frame apart from a dropped one: bad turnaround codes, a bad start field, an unknown opcode, and a header sent with no preamble. Further frames test clock-high writes that must not sample, data bits with output-enable low that must read as zero, and a write cut short by a new preamble, which commits a value made of the partial data and the preamble ones. Reset is checked both on the read-back word and on the identifier words after they have been overwritten.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CTRL_W = 4;
    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WR      = 2'b01;
    localparam logic [1:0] OP_RD      = 2'b10;
    localparam logic [1:0] TA_WR      = 2'b10;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_WRITE = 2'd1,
        ENG_READ  = 2'd2
    } eng_state_e;

    // Host control word, bit 3 down to bit 0
    typedef struct packed {
        logic di;
        logic mck;
        logic oe;
        logic dout;
    } ctrl_t;

    // Frame header as it sits in the low bits of the shift register
    typedef struct packed {
        logic [1:0]        start;
        logic [1:0]        op;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [1:0]        ta;
    } hdr_t;

    localparam int HDR_BITS = $bits(hdr_t);

    function automatic eng_state_e classify(input hdr_t h);
        if (h.start == START_CODE && h.op == OP_WR && h.ta == TA_WR)
            return ENG_WRITE;
        if (h.start == START_CODE && h.op == OP_RD && !h.ta[0])
            return ENG_READ;
        return ENG_IDLE;
    endfunction

endpackage

// File: rtl/mdio_host_reg.sv
module mdio_host_reg
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              di_load,
    input  logic              di_val,
    output logic [CTRL_W-1:0] host_rdata,
    output logic              sample_en,
    output logic              sample_bit
);

    ctrl_t ctrl_q, ctrl_d, wr_view;
    logic  last_mck_q;

    assign wr_view = ctrl_t'(host_wdata);

    always_comb begin
        ctrl_d = ctrl_q;
        if (host_wr) begin
            ctrl_d    = wr_view;
            ctrl_d.di = ctrl_q.di;
        end
        if (di_load)
            ctrl_d.di = di_val;
    end

    assign sample_en  = host_wr && !last_mck_q && wr_view.mck;
    assign sample_bit = wr_view.dout & wr_view.oe;
    assign host_rdata = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            last_mck_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            if (host_wr)
                last_mck_q <= wr_view.mck;
        end
    end

    // R9: data-in only moves when the frame engine drives it
    assert_di_readonly_R9: assert property (@(posedge clk) disable iff (rst)
        !di_load |=> (ctrl_q.di == $past(ctrl_q.di)));

    // R1: a held-high clock bit never produces a second sample
    assert_no_double_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && wr_view.mck) |=> !(host_wr && wr_view.mck && sample_en));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int SHIFT_W = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              sample_bit,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [REG_AW-1:0] rf_raddr,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              di_load,
    output logic              di_val
);

    localparam int CNT_W = $clog2(SHIFT_W + 1);
    localparam logic [CNT_W-1:0] DECODE_AT = CNT_W'(HDR_BITS);
    localparam logic [CNT_W-1:0] REARM     = CNT_W'(SHIFT_W);

    logic [SHIFT_W-1:0] shift_q, shift_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_dec;
    eng_state_e         st_q, st_d;
    logic [REG_AW-1:0]  addr_q, addr_d;
    logic [DATA_W-1:0]  dout_q, dout_d;
    hdr_t               hdr;

    always_comb begin
        shift_d  = {shift_q[SHIFT_W-2:0], sample_bit};
        cnt_dec  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        cnt_d    = (&shift_d) ? REARM : cnt_dec;
        hdr      = hdr_t'(shift_d[HDR_BITS-1:0]);
        rf_raddr = hdr.regad;
    end

    always_comb begin
        st_d    = st_q;
        addr_d  = addr_q;
        dout_d  = dout_q;
        di_load = 1'b0;
        di_val  = 1'b0;
        rf_we   = 1'b0;
        if (sample_en) begin
            if (cnt_d == DECODE_AT) begin
                st_d = classify(hdr);
                if (st_d != ENG_IDLE)
                    addr_d = hdr.regad;
                if (st_d == ENG_READ)
                    dout_d = rf_rdata;
            end
            if (cnt_d < DECODE_AT && st_d == ENG_READ) begin
                di_load = 1'b1;
                di_val  = dout_d[DATA_W-1];
                dout_d  = dout_d << 1;
            end
            if (cnt_d == '0 && st_d != ENG_IDLE) begin
                rf_we = (st_d == ENG_WRITE);
                st_d  = ENG_IDLE;
            end
        end
    end

    assign rf_waddr = addr_q;
    assign rf_wdata = shift_d[DATA_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            cnt_q   <= '0;
            st_q    <= ENG_IDLE;
            addr_q  <= '0;
            dout_q  <= '0;
        end else if (sample_en) begin
            shift_q <= shift_d;
            cnt_q   <= cnt_d;
            st_q    <= st_d;
            addr_q  <= addr_d;
            dout_q  <= dout_d;
        end
    end

    // R3: the counter never exceeds the preamble length
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= REARM);

    // R4: an operation in progress always sits at or below the decode point
    assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q != ENG_IDLE) |-> (cnt_q <= DECODE_AT));

    // R8: a commit leaves the engine idle with the frame finished
    assert_commit_end_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> (st_q == ENG_IDLE && cnt_q == '0));

    // R1: without a sample the frame state holds
    assert_hold_without_edge_R1: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(shift_q) && $stable(cnt_q)));

endmodule

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile
    import mdio_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                ID_HI_IDX = 2,
    parameter int                ID_LO_IDX = 3,
    parameter logic [DATA_W-1:0] ID_HI_VAL = 16'h0022,
    parameter logic [DATA_W-1:0] ID_LO_VAL = 16'h161A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);

    localparam int NUM_REGS = 1 << REG_AW;

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              rst_q;

    function automatic logic [DATA_W-1:0] reset_word(input int idx);
        if (idx == ID_HI_IDX) return ID_HI_VAL;
        if (idx == ID_LO_IDX) return ID_LO_VAL;
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                mem[i] <= reset_word(i);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R10: identifier words hold their reset values right after reset
    assert_id_load_R10: assert property (@(posedge clk) disable iff (rst)
        (rst_q && !rst) |-> (mem[ID_HI_IDX] == ID_HI_VAL && mem[ID_LO_IDX] == ID_LO_VAL));

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
    import mdio_pkg::*;
#(
    parameter int                SHIFT_W   = 32,
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] ID_HI_VAL = 16'h0022,
    parameter logic [DATA_W-1:0] ID_LO_VAL = 16'h161A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    output logic [CTRL_W-1:0] host_rdata
);

    logic              sample_en, sample_bit, di_load, di_val, rf_we;
    logic [REG_AW-1:0] rf_raddr, rf_waddr;
    logic [DATA_W-1:0] rf_rdata, rf_wdata;

    mdio_host_reg u_host (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .di_load    (di_load),
        .di_val     (di_val),
        .host_rdata (host_rdata),
        .sample_en  (sample_en),
        .sample_bit (sample_bit)
    );

    mdio_frame_engine #(
        .SHIFT_W (SHIFT_W),
        .DATA_W  (DATA_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .sample_bit (sample_bit),
        .rf_rdata   (rf_rdata),
        .rf_raddr   (rf_raddr),
        .rf_we      (rf_we),
        .rf_waddr   (rf_waddr),
        .rf_wdata   (rf_wdata),
        .di_load    (di_load),
        .di_val     (di_val)
    );

    mdio_phy_regfile #(
        .DATA_W    (DATA_W),
        .ID_HI_VAL (ID_HI_VAL),
        .ID_LO_VAL (ID_LO_VAL)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_raddr),
        .rdata (rf_rdata),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata)
    );

endmodule

// File: tb/mdio_mgmt_slave_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [3:0] host_wdata = 4'h0;
    logic [3:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_slave u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // {write?, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [26:0] VEC [11] = '{
        {1'b0, 5'd0,  5'd2,  16'h0022},
        {1'b0, 5'd7,  5'd3,  16'h161A},
        {1'b0, 5'd0,  5'd0,  16'h0000},
        {1'b1, 5'd1,  5'd5,  16'hA5C3},
        {1'b0, 5'd31, 5'd5,  16'hA5C3},
        {1'b1, 5'd4,  5'd31, 16'h8001},
        {1'b0, 5'd0,  5'd31, 16'h8001},
        {1'b1, 5'd0,  5'd2,  16'h1234},
        {1'b0, 5'd9,  5'd2,  16'h1234},
        {1'b1, 5'd2,  5'd7,  16'h0001},
        {1'b0, 5'd0,  5'd7,  16'h0001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] w);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic bitp(input logic oe, input logic d);
        hw({2'b00, oe, d});
        hw({2'b01, oe, d});
    endtask

    task automatic send16(input logic [15:0] v, input logic oe);
        for (int i = 15; i >= 0; i--) bitp(oe, v[i]);
    endtask

    task automatic preamble();
        for (int i = 0; i < 32; i++) bitp(1'b1, 1'b1);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] data);
        preamble();
        send16({2'b01, 2'b01, phy, ra, 2'b10}, 1'b1);
        send16(data, 1'b1);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] v);
        preamble();
        send16({2'b01, 2'b10, phy, ra, 2'b00}, 1'b1);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            bitp(1'b0, 1'b0);
            v = {v[14:0], host_rdata[3]};
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        stuck;
        do_reset();

        // R10 / R9: reset state of the read-back word
        check(host_rdata == 4'h0, "R10 reset control word", host_rdata, 4'h0);
        // R9: host cannot set data-in
        hw(4'b1000);
        check(host_rdata == 4'h0, "R9 data-in read-only after reset", host_rdata, 4'h0);
        hw(4'b0011);
        check(host_rdata == 4'b0011, "R9 readback of written bits", host_rdata, 4'b0011);

        // R3: a frame with no preamble after reset is not decoded
        send16({2'b01, 2'b01, 5'd0, 5'd9, 2'b10}, 1'b1);
        send16(16'h1357, 1'b1);
        do_read(5'd0, 5'd9, v);
        check(v == 16'h0000, "R3 no preamble no write", v, 16'h0000);

        // R4 R5 R7 R8 R10: table of frames
        foreach (VEC[k]) begin
            if (VEC[k][26]) begin
                do_write(VEC[k][25:21], VEC[k][20:16], VEC[k][15:0]);
            end else begin
                do_read(VEC[k][25:21], VEC[k][20:16], v);
                check(v == VEC[k][15:0], "R7 R8 table read", v, VEC[k][15:0]);
            end
        end
        // R7: last read left data-in at the LSB of 0x0001
        check(host_rdata[3] == 1'b1, "R7 data-in after last bit", host_rdata[3], 1'b1);

        // R9: host write with bit3 clear keeps data-in
        hw(4'b0000);
        check(host_rdata == 4'b1000, "R9 data-in kept over host write", host_rdata, 4'b1000);

        // R6: read with second turnaround bit 1 is dropped, data-in holds 1
        preamble();
        send16({2'b01, 2'b10, 5'd0, 5'd3, 2'b01}, 1'b1);
        stuck = 1'b1;
        for (int i = 0; i < 16; i++) begin
            bitp(1'b0, 1'b0);
            if (host_rdata[3] != 1'b1) stuck = 1'b0;
        end
        check(stuck, "R6 rejected read leaves data-in", stuck, 1'b1);

        // R6: read with turnaround 10 is still accepted
        preamble();
        send16({2'b01, 2'b10, 5'd0, 5'd3, 2'b10}, 1'b1);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            bitp(1'b0, 1'b0);
            v = {v[14:0], host_rdata[3]};
        end
        check(v == 16'h161A, "R6 read with turnaround 10", v, 16'h161A);

        // R5: write with turnaround 11 and 00 dropped
        preamble();
        send16({2'b01, 2'b01, 5'd0, 5'd6, 2'b11}, 1'b1);
        send16(16'hBEEF, 1'b1);
        do_read(5'd0, 5'd6, v);
        check(v == 16'h0000, "R5 write turnaround 11 dropped", v, 16'h0000);
        preamble();
        send16({2'b01, 2'b01, 5'd0, 5'd6, 2'b00}, 1'b1);
        send16(16'hBEEF, 1'b1);
        do_read(5'd0, 5'd6, v);
        check(v == 16'h0000, "R5 write turnaround 00 dropped", v, 16'h0000);

        // R4: bad start and unknown opcode dropped
        preamble();
        send16({2'b00, 2'b01, 5'd0, 5'd6, 2'b10}, 1'b1);
        send16(16'hC0DE, 1'b1);
        do_read(5'd0, 5'd6, v);
        check(v == 16'h0000, "R4 bad start dropped", v, 16'h0000);
        preamble();
        send16({2'b01, 2'b11, 5'd0, 5'd6, 2'b10}, 1'b1);
        send16(16'hC0DE, 1'b1);
        do_read(5'd0, 5'd6, v);
        check(v == 16'h0000, "R4 opcode 11 dropped", v, 16'h0000);

        // R1: extra writes with clock held high sample nothing
        preamble();
        send16({2'b01, 2'b01, 5'd0, 5'd10, 2'b10}, 1'b1);
        for (int i = 15; i >= 0; i--) begin
            logic b;
            b = 1'(16'h6C39 >> i);
            hw({2'b00, 1'b1, b});
            hw({2'b01, 1'b1, b});
            hw({2'b01, 1'b1, ~b});
        end
        do_read(5'd0, 5'd10, v);
        check(v == 16'h6C39, "R1 held clock no sample", v, 16'h6C39);

        // R2: data-out with enable low reads as zero
        do_write(5'd0, 5'd11, 16'h5555);
        preamble();
        send16({2'b01, 2'b01, 5'd0, 5'd11, 2'b10}, 1'b1);
        send16(16'hFFFF, 1'b0);
        do_read(5'd0, 5'd11, v);
        check(v == 16'h0000, "R2 enable low gives zero", v, 16'h0000);

        // R3 R8: preamble mid-write; the commit takes the partial bits plus ones
        preamble();
        send16({2'b01, 2'b01, 5'd0, 5'd12, 2'b10}, 1'b1);
        bitp(1'b1, 1'b1); bitp(1'b1, 1'b0); bitp(1'b1, 1'b1); bitp(1'b1, 1'b0); bitp(1'b1, 1'b1);
        do_read(5'd0, 5'd12, v);
        check(v == 16'hAFFF, "R3 R8 cut-short write commit", v, 16'hAFFF);

        // R10: reset restores identifier and clears others
        do_reset();
        check(host_rdata == 4'h0, "R10 control word after reset", host_rdata, 4'h0);
        do_read(5'd0, 5'd2, v);
        check(v == 16'h0022, "R10 id word 2 restored", v, 16'h0022);
        do_read(5'd0, 5'd5, v);
        check(v == 16'h0000, "R10 word 5 cleared", v, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule